// File: doc/BRIEF.md
# Repeat-Loop Exception Gate

This block sits next to the hardware repeat-loop controller of a simple in-order CPU. It is evaluated once per presented instruction. It decides whether a pending asynchronous request, meaning an interrupt or a DMA address error, may be taken at the current instruction. It makes the same decision for a pre-execution user break. When neither may be taken, the request is held pending. The decision depends on where the instruction sits inside an active repeat loop. The block also raises an illegal-slot exception when a forbidden instruction class occupies the restricted slot near the loop end.

The CPU supplies the loop bounds, the PC, a valid strobe, a decoded instruction class and the request lines. The repeat count is written through a load strobe. The block owns the down-counter and decrements it each time the loop-end instruction executes. All accept strobes and the return address are combinational on the current instruction. Pending flags and the counter are registered. Instructions are `INSN_BYTES` wide, and the loop spans the addresses from `loop_first` to `loop_last` inclusive.

Top module: `rptloop_exc_gate`

## Requirements
- R1: While the repeat count is non-zero, an instruction inside the loop is one of three slot kinds. The last three instructions up to `loop_last` are kind C. `loop_first` is kind B unless it is already kind C. Every other instruction is kind A. An asynchronous request raised at a B or C instruction is not taken, and it is taken at the next A instruction with `ret_pc` equal to that instruction's address.
- R2: A user break raised at a kind-B instruction is taken at that instruction, and `ret_pc` holds its address.
- R3: A user break raised at a kind-C instruction is held. It is taken at the next A or B instruction, and `ret_pc` holds that instruction's address.
- R4: In a loop of four or fewer instructions, no asynchronous request is taken at any instruction inside the loop while the count is non-zero.
- R5: The check slot is `loop_last - 2*INSN_BYTES` when the loop has at least three instructions, and `loop_first` otherwise. At that slot, instruction classes 1 (branch), 2 (repeat setup) and 3 (status or loop-bound register load) pulse `illegal_take` while the count is non-zero, with `ret_pc` equal to that slot's address. Class 0 does not.
- R6: `illegal_take` suppresses both accept strobes in its cycle. Any held requests stay pending.
- R7: Each valid, non-illegal execution of `loop_last` while the count is non-zero decrements the count. When the count reaches zero the loop is inactive, and held requests are taken at the next instruction.
- R8: When a user break and an asynchronous request are both acceptable in one cycle, only `ubrk_take` fires. The asynchronous request stays pending for a later instruction.
- R9: A request pulse seen while no instruction is valid is remembered. Each pending flag clears only in the cycle of its own accept strobe, so a second accept needs a new request.
- R10: After reset all strobes are low, nothing is pending, and the count is zero.
- R11: With a count of zero, every instruction is kind A, including those at the loop addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_first | input | AW | Address of the first loop instruction |
| loop_last | input | AW | Address of the last loop instruction |
| cnt_wr | input | 1 | Load the repeat count |
| cnt_wdata | input | CW | Repeat count to load |
| insn_vld | input | 1 | An instruction is presented this cycle |
| insn_pc | input | AW | Address of the presented instruction |
| insn_cls | input | 2 | Class: 0 plain, 1 branch, 2 repeat setup, 3 control register load |
| async_req | input | 1 | Interrupt or DMA address error request pulse |
| ubrk_req | input | 1 | Pre-execution user break request pulse |
| async_take | output | 1 | Asynchronous request accepted at this instruction |
| ubrk_take | output | 1 | User break accepted at this instruction |
| illegal_take | output | 1 | Illegal-slot exception at this instruction |
| ret_pc | output | AW | Address to save as return PC, zero when nothing is taken |

## Verification
The bench drives loops of eight and four instructions through several passes. It raises requests at the first slot, at the tail slots and at the loop end. A design that decremented the count on the wrong address, or that missed the inactive state, would take requests inside the tail or hold them after the loop ends. The illegal-slot tests use every forbidden class at the check slot and a forbidden class one slot later. They then confirm that a request held across the fault is still taken afterwards, which exposes a gate that drops pending flags or lets the fault and an accept fire together. Simultaneous requests and requests that arrive without a valid instruction expose wrong priority and non-sticky flags.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN  = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_RPTSET = 2'd2,
        CLS_CTRLLD = 2'd3
    } insn_cls_e;

    typedef enum logic [1:0] {
        SLOT_A = 2'd0,
        SLOT_B = 2'd1,
        SLOT_C = 2'd2
    } slot_e;

    localparam int unsigned TAIL_SLOTS = 3;

    function automatic logic cls_forbidden(input insn_cls_e c);
        return (c != CLS_PLAIN);
    endfunction

endpackage

// File: rtl/rlg_slot_classify.sv
module rlg_slot_classify
    import rlg_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned INSN_BYTES = 2
) (
    input  logic [AW-1:0] loop_first,
    input  logic [AW-1:0] loop_last,
    input  logic [AW-1:0] pc,
    input  logic          active,
    input  insn_cls_e     cls,
    output slot_e         slot,
    output logic          bad_slot
);
    localparam int unsigned SH = (INSN_BYTES > 1) ? $clog2(INSN_BYTES) : 0;
    localparam logic [AW-1:0] STEP2 = AW'(2) << SH;

    logic [AW-1:0] dist_end;
    logic [AW-1:0] span_m1;
    logic [AW-1:0] chk_addr;
    logic          in_loop;
    logic          is_tail;

    always_comb begin
        in_loop  = active && (pc >= loop_first) && (pc <= loop_last);
        dist_end = (loop_last - pc) >> SH;
        span_m1  = (loop_last - loop_first) >> SH;
        is_tail  = in_loop && (dist_end < AW'(TAIL_SLOTS));
        chk_addr = (span_m1 >= AW'(2)) ? (loop_last - STEP2) : loop_first;
        if (is_tail)
            slot = SLOT_C;
        else if (in_loop && pc == loop_first)
            slot = SLOT_B;
        else
            slot = SLOT_A;
        bad_slot = active && (pc == chk_addr) && cls_forbidden(cls);
    end

endmodule

// File: rtl/rlg_rpt_counter.sv
module rlg_rpt_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          dec_en,
    output logic [CW-1:0] cnt_q,
    output logic          active
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= cnt_wdata;
        else if (dec_en && cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/rlg_pend_arb.sv
module rlg_pend_arb
    import rlg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  illegal,
    input  slot_e slot,
    input  logic  async_req,
    input  logic  ubrk_req,
    output logic  async_take,
    output logic  ubrk_take
);
    logic async_pend_q, ubrk_pend_q;
    logic async_eff, ubrk_eff;
    logic ok_ubrk, ok_async;

    always_comb begin
        async_eff  = async_pend_q | async_req;
        ubrk_eff   = ubrk_pend_q | ubrk_req;
        ok_ubrk    = vld && !illegal && (slot != SLOT_C);
        ok_async   = vld && !illegal && (slot == SLOT_A);
        ubrk_take  = ubrk_eff && ok_ubrk;
        async_take = async_eff && ok_async && !ubrk_take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            async_pend_q <= 1'b0;
            ubrk_pend_q  <= 1'b0;
        end else begin
            async_pend_q <= async_eff && !async_take;
            ubrk_pend_q  <= ubrk_eff && !ubrk_take;
        end
    end

endmodule

// File: rtl/rptloop_exc_gate.sv
module rptloop_exc_gate
    import rlg_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 8,
    parameter int unsigned INSN_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] loop_first,
    input  logic [AW-1:0] loop_last,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          insn_vld,
    input  logic [AW-1:0] insn_pc,
    input  logic [1:0]    insn_cls,
    input  logic          async_req,
    input  logic          ubrk_req,
    output logic          async_take,
    output logic          ubrk_take,
    output logic          illegal_take,
    output logic [AW-1:0] ret_pc
);
    logic [CW-1:0] cnt_q;
    logic          active;
    slot_e         slot;
    logic          bad_slot;
    logic          dec_en;

    rlg_slot_classify #(.AW(AW), .INSN_BYTES(INSN_BYTES)) cls_i (
        .loop_first (loop_first),
        .loop_last  (loop_last),
        .pc         (insn_pc),
        .active     (active),
        .cls        (insn_cls_e'(insn_cls)),
        .slot       (slot),
        .bad_slot   (bad_slot)
    );

    assign illegal_take = insn_vld && bad_slot;
    assign dec_en       = insn_vld && active && (insn_pc == loop_last) && !illegal_take;

    rlg_rpt_counter #(.CW(CW)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .dec_en    (dec_en),
        .cnt_q     (cnt_q),
        .active    (active)
    );

    rlg_pend_arb arb_i (
        .clk        (clk),
        .rst        (rst),
        .vld        (insn_vld),
        .illegal    (illegal_take),
        .slot       (slot),
        .async_req  (async_req),
        .ubrk_req   (ubrk_req),
        .async_take (async_take),
        .ubrk_take  (ubrk_take)
    );

    assign ret_pc = (async_take || ubrk_take || illegal_take) ? insn_pc : '0;

endmodule

// File: rtl/rlg_gate_chk.sv
module rlg_gate_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 8,
    parameter int unsigned INSN_BYTES = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] loop_first,
    input logic [AW-1:0] loop_last,
    input logic          cnt_wr,
    input logic          insn_vld,
    input logic [AW-1:0] insn_pc,
    input logic          async_req,
    input logic          async_take,
    input logic          ubrk_take,
    input logic          illegal_take,
    input logic [AW-1:0] ret_pc,
    input logic [CW-1:0] cnt_q
);
    localparam int unsigned SH = (INSN_BYTES > 1) ? $clog2(INSN_BYTES) : 0;

    logic in_tail;
    assign in_tail = (cnt_q != '0) && (insn_pc >= loop_first) && (insn_pc <= loop_last)
                     && (((loop_last - insn_pc) >> SH) < AW'(3));

    // R6, R8: at most one strobe per instruction
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({async_take, ubrk_take, illegal_take}));

    // R1: strobes only on a presented instruction, with its address saved
    p_ret_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (async_take || ubrk_take || illegal_take) |-> (insn_vld && ret_pc == insn_pc));

    // R1, R3: nothing taken in the tail of a live loop
    p_tail_hold_r3: assert property (@(posedge clk) disable iff (rst)
        in_tail |-> (!async_take && !ubrk_take));

    // R9: after an accept the flag is clear, so a new accept needs a new pulse
    p_flag_clears_r9: assert property (@(posedge clk) disable iff (rst)
        async_take |=> (!async_take || async_req));

    // R7: loop-end execution decrements a live count
    p_count_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && cnt_q != '0 && insn_pc == loop_last && !illegal_take && !cnt_wr)
        |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

bind rptloop_exc_gate rlg_gate_chk #(.AW(AW), .CW(CW), .INSN_BYTES(INSN_BYTES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .loop_first   (loop_first),
    .loop_last    (loop_last),
    .cnt_wr       (cnt_wr),
    .insn_vld     (insn_vld),
    .insn_pc      (insn_pc),
    .async_req    (async_req),
    .async_take   (async_take),
    .ubrk_take    (ubrk_take),
    .illegal_take (illegal_take),
    .ret_pc       (ret_pc),
    .cnt_q        (cnt_q)
);

// File: tb/rptloop_exc_gate_tb.sv
module rptloop_exc_gate_tb_top;
    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] loop_first, loop_last;
    logic          cnt_wr;
    logic [CW-1:0] cnt_wdata;
    logic          insn_vld;
    logic [AW-1:0] insn_pc;
    logic [1:0]    insn_cls;
    logic          async_req, ubrk_req;
    logic          async_take, ubrk_take, illegal_take;
    logic [AW-1:0] ret_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rptloop_exc_gate #(.AW(AW), .CW(CW), .INSN_BYTES(2)) dut_i (.*);

    task automatic idle_inputs();
        cnt_wr = 0; cnt_wdata = '0; insn_vld = 0; insn_pc = '0;
        insn_cls = 2'd0; async_req = 0; ubrk_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic load_cnt(input int c);
        @(negedge clk);
        idle_inputs();
        cnt_wr = 1; cnt_wdata = CW'(c);
    endtask

    // one instruction cycle, then compare outputs before the next edge
    task automatic cyc(input string req, input bit v, input int pc, input int cls,
                       input bit ar, input bit br,
                       input bit ea, input bit eb, input bit ei, input int epc);
        logic [AW-1:0] exp_pc;
        @(negedge clk);
        idle_inputs();
        insn_vld = v; insn_pc = AW'(pc); insn_cls = 2'(cls);
        async_req = ar; ubrk_req = br;
        #2;
        exp_pc = (ea || eb || ei) ? AW'(epc) : '0;
        n_chk++;
        if (async_take !== ea || ubrk_take !== eb || illegal_take !== ei || ret_pc !== exp_pc) begin
            n_bad++;
            $display("FAIL %s pc=%h: got a=%b b=%b i=%b ret=%h, expected a=%b b=%b i=%b ret=%h",
                     req, pc, async_take, ubrk_take, illegal_take, ret_pc, ea, eb, ei, exp_pc);
        end
    endtask

    task automatic set_loop(input int f, input int l);
        loop_first = AW'(f); loop_last = AW'(l);
    endtask

    // R10 reset state, R11 zero count means every slot is A
    task automatic t_reset_zero();
        set_loop('h100, 'h10E);
        do_reset();
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R10", 1, 'h10C, 0, 0, 0, 0, 0, 0, 0);
        cyc("R11", 1, 'h10C, 0, 1, 0, 1, 0, 0, 'h10C);
        cyc("R11", 1, 'h10A, 1, 0, 0, 0, 0, 0, 0);
        cyc("R11", 1, 'h100, 0, 0, 1, 0, 1, 0, 'h100);
    endtask

    // R1 async held at B and C, taken at next A
    task automatic t_async_hold();
        set_loop('h100, 'h10E);
        do_reset();
        load_cnt(2);
        cyc("R1", 1, 'h100, 0, 1, 0, 0, 0, 0, 0);
        cyc("R1", 1, 'h102, 0, 0, 0, 1, 0, 0, 'h102);
        cyc("R1", 1, 'h10C, 0, 1, 0, 0, 0, 0, 0);
        cyc("R1", 1, 'h10E, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1", 1, 'h100, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1", 1, 'h102, 0, 0, 0, 1, 0, 0, 'h102);
    endtask

    // R2 ubrk at B taken; R3 ubrk at C held until B
    task automatic t_ubrk();
        set_loop('h100, 'h10E);
        do_reset();
        load_cnt(3);
        cyc("R2", 1, 'h100, 0, 0, 1, 0, 1, 0, 'h100);
        cyc("R3", 1, 'h10A, 0, 0, 1, 0, 0, 0, 0);
        cyc("R3", 1, 'h10C, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 'h10E, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 'h100, 0, 0, 0, 0, 1, 0, 'h100);
        cyc("R3", 1, 'h10C, 0, 0, 1, 0, 0, 0, 0);
        cyc("R3", 1, 'h10E, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 'h100, 0, 0, 0, 0, 1, 0, 'h100);
    endtask

    // R4 short loop never takes async; R7 taken right after the loop ends
    task automatic t_short_loop();
        set_loop('h200, 'h206);
        do_reset();
        load_cnt(2);
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++)
                cyc("R4", 1, 'h200 + 2*k, 0, (k == 0 && p == 0), 0, 0, 0, 0, 0);
        end
        cyc("R7", 1, 'h208, 0, 0, 0, 1, 0, 0, 'h208);
    endtask

    // R7 exit with a count of one: pending request taken at next instruction
    task automatic t_exit();
        set_loop('h100, 'h10E);
        do_reset();
        load_cnt(1);
        cyc("R7", 1, 'h10C, 0, 1, 1, 0, 0, 0, 0);
        cyc("R7", 1, 'h10E, 0, 0, 0, 0, 0, 0, 0);
        cyc("R7", 1, 'h10C, 0, 0, 0, 0, 1, 0, 'h10C);
        cyc("R7", 1, 'h10E, 0, 0, 0, 1, 0, 0, 'h10E);
    endtask

    // R5 illegal classes at the check slot, R6 held requests survive
    task automatic t_illegal();
        set_loop('h100, 'h10E);
        do_reset();
        load_cnt(2);
        cyc("R6", 1, 'h100, 0, 1, 0, 0, 0, 0, 0);
        cyc("R5", 1, 'h10A, 1, 0, 0, 0, 0, 1, 'h10A);
        cyc("R5", 1, 'h10A, 2, 0, 1, 0, 0, 1, 'h10A);
        cyc("R5", 1, 'h10A, 3, 0, 0, 0, 0, 1, 'h10A);
        cyc("R5", 1, 'h10A, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 'h10C, 2, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 'h10E, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6", 1, 'h100, 0, 0, 0, 0, 1, 0, 'h100);
        cyc("R6", 1, 'h102, 0, 0, 0, 1, 0, 0, 'h102);
    endtask

    // R8 ubrk wins over async, async follows
    task automatic t_prio();
        set_loop('h100, 'h10E);
        do_reset();
        cyc("R8", 1, 'h300, 0, 1, 1, 0, 1, 0, 'h300);
        cyc("R8", 1, 'h302, 0, 0, 0, 1, 0, 0, 'h302);
        cyc("R8", 1, 'h304, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R9 pulses without a valid instruction are remembered; flag clears on accept
    task automatic t_sticky();
        set_loop('h100, 'h10E);
        do_reset();
        cyc("R9", 0, 'h400, 0, 1, 0, 0, 0, 0, 0);
        cyc("R9", 0, 'h400, 0, 0, 1, 0, 0, 0, 0);
        cyc("R9", 1, 'h400, 0, 0, 0, 0, 1, 0, 'h400);
        cyc("R9", 1, 'h402, 0, 0, 0, 1, 0, 0, 'h402);
        cyc("R9", 1, 'h404, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        set_loop('h100, 'h10E);
        t_reset_zero();
        t_async_hold();
        t_ubrk();
        t_short_loop();
        t_exit();
        t_illegal();
        t_prio();
        t_sticky();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule